// File: doc/BRIEF.md
# Programmable Defect Signature Detector

This block watches a wide vector of status signals tapped from the units of a processor. It raises a match when one of a small set of loaded defect signatures becomes true. Each signature is loaded through a narrow configuration port and holds four things: a selection table that picks a few of the tapped signals, a sum-of-products condition over those picked signals, a class bit, and an evaluation mode. In the class bit, 0 means the defect can be caught before it strikes and 1 means after. Its recovery unit uses the class to choose a recovery action.

A concurrent signature needs all of its signals in the same cycle. A complex signature remembers each picked signal in a sticky latch, so a condition whose parts occur in different cycles still matches. The latches are emptied by an optional cycle window, by an explicit clear input, by disarming the signature, or when that signature is reported.

One reporting state machine picks the lowest-numbered true signature and emits a one-cycle pulse with its index and class. It then stays quiet until no condition is true for a cycle. Its states are ARMED, FIRE and QUIET. The transitions are ARMED to FIRE when any signature hits, FIRE to QUIET when a hit is still present, FIRE to ARMED when none is, and QUIET to ARMED once no signature hits.

Top module: `defect_sig_detector`

## Requirements
- R1: After reset, match_o, match_idx and match_class are 0 and every signature is disarmed, so no tap pattern produces a match.
- R2: A write addresses signature cfg_sig, and cfg_kind selects what is written.
  - Kind 0 is control: data bit 0 is armed, bit 1 is class, bit 2 is complex mode, and bits 15:8 are the window.
  - Kind 1 writes selection entry cfg_idx with tap number data[5:0].
  - Kind 2 writes the true mask of term cfg_idx[1:0].
  - Kind 3 writes the complement mask of term cfg_idx[1:0].
- R3: While a signature is armed, every write to it is ignored except a control write with bit 0 clear, which disarms it and changes nothing else.
- R4: Selected signal k of a signature equals taps[entry k]; taps that no entry names have no effect.
- R5: A term is true when every true-mask bit is 1 and every complement-mask bit is 0 in the evaluated vector, and when at least one of its two masks is non-zero. A signature's condition is the OR of its four terms.
- R6: In concurrent mode the condition is evaluated on the selected signals of the current cycle, and a true condition gives match_o high in the following cycle.
- R7: In complex mode every selected signal is held in a sticky latch, and the condition is evaluated on the latches ORed with the current selected signals.
- R8: With a non-zero window W, the latches empty W cycles after the first latched occurrence. A later signal d cycles after the first one therefore completes a match exactly when d <= W. A window of 0 never expires.
- R9: sticky_clr[s] empties the latches of signature s at the next clock edge.
- R10: When several signatures are true in one cycle, the lowest index wins, and match_idx and match_class report that signature.
- R11: match_o lasts one cycle. A condition that stays true gives no further pulse until a cycle passes with no signature true. The reported signature's latches are emptied.
- R12: A disarming control write suppresses that signature's hit in the same cycle it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps | input | 64 | Tapped status signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sig | input | 3 | Signature addressed by the write |
| cfg_kind | input | 2 | Write kind: control, selection entry, true mask, complement mask |
| cfg_idx | input | 4 | Selection entry or term number |
| cfg_data | input | 16 | Write data |
| sticky_clr | input | 8 | Per-signature latch clear |
| match_o | output | 1 | One-cycle match pulse |
| match_idx | output | 3 | Index of the reported signature |
| match_class | output | 1 | Class of the reported signature (0 pre, 1 post) |

## Verification
Two collisions can land in one cycle.

The first is a disarming control write and a true condition on the same signature. The bench raises the selected tap in the same cycle as the write. It then expects match_o to stay low in that cycle and the next, while the tap is still high.

The second is several signatures becoming true together. The bench sweeps all 255 non-empty subsets of eight signatures, each watching its own tap. For every subset it compares match_idx and match_class with the lowest set bit and that signature's programmed class.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_SEL  = 2'd1,
        K_TRUE = 2'd2,
        K_COMP = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_QUIET = 2'd2
    } rpt_state_e;

    localparam int CTL_VALID   = 0;
    localparam int CTL_CLASS   = 1;
    localparam int CTL_COMPLEX = 2;
    localparam int CTL_WIN_LSB = 8;

endpackage

// File: rtl/dsd_pla.sv
module dsd_pla #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 4
) (
    input  logic [N_IN-1:0]              vec,
    input  logic [N_TERM-1:0][N_IN-1:0]  tmask,
    input  logic [N_TERM-1:0][N_IN-1:0]  cmask,
    output logic                         fire
);

    logic [N_TERM-1:0] term;

    generate
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            assign term[t] = ((tmask[t] & ~vec) == '0)
                          && ((cmask[t] & vec) == '0)
                          && ((tmask[t] | cmask[t]) != '0);
        end
    endgenerate

    assign fire = |term;

endmodule

// File: rtl/dsd_sig_slice.sv
module dsd_sig_slice import dsd_pkg::*; #(
    parameter int N_TAP  = 64,
    parameter int N_SEL  = 16,
    parameter int N_TERM = 4,
    parameter int WIN_W  = 8,
    parameter int CFG_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAP-1:0]  taps,
    input  logic              we,
    input  logic [1:0]        kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CFG_W-1:0]  data,
    input  logic              clr,
    input  logic              consume,
    output logic              hit,
    output logic              cls
);

    localparam int TAP_W   = $clog2(N_TAP);
    localparam int SEL_IW  = $clog2(N_SEL);
    localparam int TERM_IW = $clog2(N_TERM);

    logic                            valid_q;
    logic                            cls_q;
    logic                            cplx_q;
    logic [WIN_W-1:0]                win_q;
    logic [N_SEL-1:0][TAP_W-1:0]     sel_q;
    logic [N_TERM-1:0][N_SEL-1:0]    tmask_q;
    logic [N_TERM-1:0][N_SEL-1:0]    cmask_q;
    logic [N_SEL-1:0]                lat_q;
    logic [WIN_W-1:0]                cnt_q;

    logic [N_SEL-1:0]                sel_vec;
    logic [N_SEL-1:0]                eff_vec;
    logic                            cond;
    logic                            disarm_now;
    logic                            expire;
    cfg_kind_e                       kind_e;

    assign kind_e = cfg_kind_e'(kind);

    // Configuration store: only a disarmed signature accepts new content.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cls_q   <= 1'b0;
            cplx_q  <= 1'b0;
            win_q   <= '0;
            sel_q   <= '0;
            tmask_q <= '0;
            cmask_q <= '0;
        end else if (we) begin
            if (kind_e == K_CTRL) begin
                if (!valid_q) begin
                    valid_q <= data[CTL_VALID];
                    cls_q   <= data[CTL_CLASS];
                    cplx_q  <= data[CTL_COMPLEX];
                    win_q   <= data[CTL_WIN_LSB +: WIN_W];
                end else if (!data[CTL_VALID]) begin
                    valid_q <= 1'b0;
                end
            end else if (!valid_q) begin
                unique case (kind_e)
                    K_SEL:   sel_q[idx[SEL_IW-1:0]]    <= data[TAP_W-1:0];
                    K_TRUE:  tmask_q[idx[TERM_IW-1:0]] <= data[N_SEL-1:0];
                    K_COMP:  cmask_q[idx[TERM_IW-1:0]] <= data[N_SEL-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Selection stage
    generate
        for (genvar k = 0; k < N_SEL; k++) begin : g_sel
            assign sel_vec[k] = taps[sel_q[k]];
        end
    endgenerate

    // Sticky latches with window expiry
    assign expire = cplx_q && (win_q != '0) && (lat_q != '0)
                 && (cnt_q == win_q - WIN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            cnt_q <= '0;
        end else if (!valid_q || !cplx_q || clr || consume || expire) begin
            lat_q <= '0;
            cnt_q <= '0;
        end else begin
            lat_q <= lat_q | sel_vec;
            if (lat_q != '0) begin
                cnt_q <= cnt_q + WIN_W'(1);
            end
        end
    end

    assign eff_vec = cplx_q ? (lat_q | sel_vec) : sel_vec;

    dsd_pla #(
        .N_IN   (N_SEL),
        .N_TERM (N_TERM)
    ) u_pla (
        .vec   (eff_vec),
        .tmask (tmask_q),
        .cmask (cmask_q),
        .fire  (cond)
    );

    assign disarm_now = we && (kind_e == K_CTRL) && !data[CTL_VALID];
    assign hit        = valid_q && !disarm_now && cond;
    assign cls        = cls_q;

endmodule

// File: rtl/dsd_report.sv
module dsd_report import dsd_pkg::*; #(
    parameter int N_SIG = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SIG-1:0]          hit_vec,
    input  logic [N_SIG-1:0]          cls_vec,
    output logic                      match_o,
    output logic [$clog2(N_SIG)-1:0]  match_idx,
    output logic                      match_cls,
    output logic [N_SIG-1:0]          consume
);

    localparam int SIG_W = $clog2(N_SIG);

    rpt_state_e         state_q;
    rpt_state_e         state_d;
    logic               any_hit;
    logic [SIG_W-1:0]   win_idx;
    logic               take;

    assign any_hit = |hit_vec;

    always_comb begin
        win_idx = '0;
        for (int i = N_SIG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx = SIG_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (any_hit)  state_d = ST_FIRE;
            ST_FIRE:  state_d = any_hit ? ST_QUIET : ST_ARMED;
            ST_QUIET: if (!any_hit) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    assign take = (state_q == ST_ARMED) && any_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_idx <= '0;
            match_cls <= 1'b0;
        end else if (take) begin
            match_idx <= win_idx;
            match_cls <= cls_vec[win_idx];
        end
    end

    assign match_o = (state_q == ST_FIRE);
    assign consume = take ? (N_SIG'(1) << win_idx) : '0;

endmodule

// File: rtl/defect_sig_detector.sv
module defect_sig_detector import dsd_pkg::*; #(
    parameter int N_TAP  = 64,
    parameter int N_SIG  = 8,
    parameter int N_SEL  = 16,
    parameter int N_TERM = 4,
    parameter int WIN_W  = 8,
    parameter int CFG_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TAP-1:0]          taps,
    input  logic                      cfg_we,
    input  logic [$clog2(N_SIG)-1:0]  cfg_sig,
    input  logic [1:0]                cfg_kind,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [CFG_W-1:0]          cfg_data,
    input  logic [N_SIG-1:0]          sticky_clr,
    output logic                      match_o,
    output logic [$clog2(N_SIG)-1:0]  match_idx,
    output logic                      match_class
);

    localparam int SIG_W = $clog2(N_SIG);

    logic [N_SIG-1:0] hit_vec;
    logic [N_SIG-1:0] cls_vec;
    logic [N_SIG-1:0] consume;

    generate
        for (genvar s = 0; s < N_SIG; s++) begin : g_slice
            dsd_sig_slice #(
                .N_TAP  (N_TAP),
                .N_SEL  (N_SEL),
                .N_TERM (N_TERM),
                .WIN_W  (WIN_W),
                .CFG_W  (CFG_W),
                .IDX_W  (IDX_W)
            ) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .taps    (taps),
                .we      (cfg_we && (cfg_sig == SIG_W'(s))),
                .kind    (cfg_kind),
                .idx     (cfg_idx),
                .data    (cfg_data),
                .clr     (sticky_clr[s]),
                .consume (consume[s]),
                .hit     (hit_vec[s]),
                .cls     (cls_vec[s])
            );
        end
    endgenerate

    dsd_report #(
        .N_SIG (N_SIG)
    ) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .cls_vec   (cls_vec),
        .match_o   (match_o),
        .match_idx (match_idx),
        .match_cls (match_class),
        .consume   (consume)
    );

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int N_SIG = 8,
    parameter int CFG_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(N_SIG)-1:0]  cfg_sig,
    input  logic [1:0]                cfg_kind,
    input  logic [CFG_W-1:0]          cfg_data,
    input  logic [N_SIG-1:0]          hit_vec,
    input  logic                      match_o,
    input  logic [$clog2(N_SIG)-1:0]  match_idx
);

    logic [N_SIG-1:0] hit_d;
    logic [N_SIG-1:0] below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_d <= '0;
        else        hit_d <= hit_vec;
    end

    assign below = (N_SIG'(1) << match_idx) - N_SIG'(1);

    // R10: reported index is the lowest signature true one cycle earlier
    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (hit_d[match_idx] && ((hit_d & below) == '0)));

    // R11: a pulse lasts one cycle
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    // R11: conditions that persist after a pulse give no new pulse
    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_d != '0) && (hit_vec != '0) && !match_o) |=> !match_o);

    // R12: a disarming write masks the hit of its signature at once
    p_disarm_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_kind == 2'd0) && !cfg_data[0]) |-> !hit_vec[cfg_sig]);

endmodule

bind defect_sig_detector dsd_checker #(
    .N_SIG (N_SIG),
    .CFG_W (CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sig   (cfg_sig),
    .cfg_kind  (cfg_kind),
    .cfg_data  (cfg_data),
    .hit_vec   (hit_vec),
    .match_o   (match_o),
    .match_idx (match_idx)
);

// File: tb/tb_defect_sig_detector.sv
module tb_defect_sig_detector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] taps;
    logic        cfg_we;
    logic [2:0]  cfg_sig;
    logic [1:0]  cfg_kind;
    logic [3:0]  cfg_idx;
    logic [15:0] cfg_data;
    logic [7:0]  sticky_clr;
    logic        match_o;
    logic [2:0]  match_idx;
    logic        match_class;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    defect_sig_detector dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .taps        (taps),
        .cfg_we      (cfg_we),
        .cfg_sig     (cfg_sig),
        .cfg_kind    (cfg_kind),
        .cfg_idx     (cfg_idx),
        .cfg_data    (cfg_data),
        .sticky_clr  (sticky_clr),
        .match_o     (match_o),
        .match_idx   (match_idx),
        .match_class (match_class)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int s, input int k, input int i, input int d);
        cfg_we   = 1'b1;
        cfg_sig  = 3'(s);
        cfg_kind = 2'(k);
        cfg_idx  = 4'(i);
        cfg_data = 16'(d);
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic idle(input int n);
        taps = '0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; taps = '0; cfg_we = 1'b0; cfg_sig = '0; cfg_kind = '0;
        cfg_idx = '0; cfg_data = '0; sticky_clr = '0;
        repeat (3) tick();
        chk(match_o == 1'b0 && match_idx == 3'd0 && match_class == 1'b0,
            "R1 reset outputs", {match_o, match_idx, match_class}, 0);
        rst_n = 1'b1;
        taps = '1;
        tick(); tick();
        chk(match_o == 1'b0, "R1 disarmed after reset", match_o, 0);
        idle(2);

        // R2 R5 R6: concurrent sum-of-products sweep on signature 0
        for (int k = 0; k < 16; k++) cfg(0, 1, k, k);
        cfg(0, 2, 0, 16'h0003);
        cfg(0, 2, 1, 16'h0004);
        cfg(0, 3, 1, 16'h0008);
        cfg(0, 0, 0, 16'h0003);
        for (int p = 0; p < 16; p++) begin
            bit e;
            e = ((p & 3) == 3) || (((p & 4) != 0) && ((p & 8) == 0));
            taps = 64'(p) | 64'hFFFF_0000_0000_0000;
            tick();
            chk(match_o == e, "R5 R6 sum-of-products", match_o, 64'(e));
            if (e) chk(match_idx == 3'd0 && match_class == 1'b1,
                       "R2 R10 index and class", {match_idx, match_class}, 1);
            idle(2);
        end

        // R4: every selection value against every tap
        cfg(0, 0, 0, 0);
        cfg(0, 2, 0, 16'h0001);
        cfg(0, 2, 1, 0);
        cfg(0, 3, 1, 0);
        for (int j = 0; j < 64; j++) begin
            cfg(0, 0, 0, 0);
            cfg(0, 1, 0, j);
            cfg(0, 0, 0, 1);
            for (int k = 0; k < 64; k++) begin
                taps = 64'd1 << k;
                tick();
                chk(match_o == (k == j), "R4 tap selection", match_o, 64'(k == j));
                idle(2);
            end
        end

        // R3: write to an armed signature is ignored (sig0 still selects tap 63)
        cfg(0, 1, 0, 5);
        taps = 64'd1 << 63; tick();
        chk(match_o == 1'b1, "R3 armed write ignored, old tap", match_o, 1);
        idle(2);
        taps = 64'd1 << 5; tick();
        chk(match_o == 1'b0, "R3 armed write ignored, new tap", match_o, 0);
        idle(2);

        // R12: disarm in the same cycle as a hit
        taps = 64'd1 << 63;
        cfg(0, 0, 0, 0);
        chk(match_o == 1'b0, "R12 disarm same cycle", match_o, 0);
        tick();
        chk(match_o == 1'b0, "R12 stays disarmed", match_o, 0);
        idle(2);
        cfg(0, 0, 0, 1);

        // R11: one pulse per occurrence
        taps = 64'd1 << 63;
        tick();
        chk(match_o == 1'b1, "R11 first pulse", match_o, 1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(match_o == 1'b0, "R11 no repeat while held", match_o, 0);
        end
        idle(1);
        taps = 64'd1 << 63; tick();
        chk(match_o == 1'b1, "R11 pulse after release", match_o, 1);
        idle(2);

        // R10: priority over all subsets of eight signatures
        cfg(0, 0, 0, 0);
        for (int s = 0; s < 8; s++) begin
            cfg(s, 1, 0, 40 + s);
            cfg(s, 2, 0, 16'h0001);
            cfg(s, 0, 0, 1 | ((s & 1) << 1));
        end
        for (int m = 0; m < 256; m++) begin
            int low;
            low = 0;
            for (int b = 7; b >= 0; b--) if (m[b]) low = b;
            taps = 64'(m) << 40;
            tick();
            chk(match_o == (m != 0), "R10 subset pulse", match_o, 64'(m != 0));
            if (m != 0) chk(match_idx == 3'(low) && match_class == low[0],
                            "R10 lowest index wins", {match_idx, match_class},
                            {3'(low), low[0]});
            idle(2);
        end

        // R7 R8: complex signature 1, window 4, second signal d cycles later
        cfg(1, 0, 0, 0);
        cfg(1, 1, 0, 10);
        cfg(1, 1, 1, 11);
        cfg(1, 2, 0, 16'h0003);
        cfg(1, 0, 0, 16'h0405);
        for (int d = 0; d < 8; d++) begin
            if (d == 0) begin
                taps = (64'd1 << 10) | (64'd1 << 11); tick();
                chk(match_o == 1'b1, "R7 both in one cycle", match_o, 1);
            end else begin
                taps = 64'd1 << 10; tick();
                chk(match_o == 1'b0, "R7 first part alone", match_o, 0);
                for (int i = 1; i < d; i++) begin
                    taps = '0; tick();
                    chk(match_o == 1'b0, "R7 gap", match_o, 0);
                end
                taps = 64'd1 << 11; tick();
                chk(match_o == (d <= 4), "R8 window edge", match_o, 64'(d <= 4));
                if (d <= 4) chk(match_idx == 3'd1, "R7 complex index", match_idx, 1);
            end
            taps = '0; sticky_clr = 8'h02; tick(); sticky_clr = '0;
            idle(2);
        end

        // R9: explicit clear drops the first part
        taps = 64'd1 << 10; tick();
        taps = '0; sticky_clr = 8'h02; tick(); sticky_clr = '0;
        taps = 64'd1 << 11; tick();
        chk(match_o == 1'b0, "R9 sticky clear", match_o, 0);
        taps = '0; sticky_clr = 8'h02; tick(); sticky_clr = '0;
        idle(2);

        // R8: window 0 never expires
        cfg(1, 0, 0, 0);
        cfg(1, 0, 0, 16'h0005);
        taps = 64'd1 << 10; tick();
        idle(20);
        taps = 64'd1 << 11; tick();
        chk(match_o == 1'b1, "R8 zero window holds", match_o, 1);
        idle(2);

        // R5: a term with empty masks never fires
        cfg(2, 0, 0, 0);
        cfg(2, 2, 0, 0);
        cfg(2, 0, 0, 1);
        taps = 64'd1 << 42; tick();
        chk(match_o == 1'b0, "R5 empty term", match_o, 0);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule